// File: doc/BRIEF.md
# Auto-Increment Transfer Data Buffer

This block is a 512-byte staging store that sits between a 32-bit register-mapped host port and a byte-wide port used by a flash sequencer. Software moves a whole transfer through one data register. It first programs a control register with a direction, an auto-increment enable and a starting word address, then reads or writes the data register once per 32-bit word. When auto-increment is on, every access that matches the programmed direction moves the word address on by one.

The sequencer sees the same storage one byte at a time. A separate offset register holds the byte position where the sequencer begins. Software normally sets it to zero before each transaction. A start pulse loads the sequencer byte pointer from that offset, and each byte the sequencer reads or writes advances the pointer. Words and bytes are related little-endian, so a transfer whose length is not a multiple of four ends with one full-word host access. Only the low-order bytes of that word carry data.

Top module: `xfer_dbuf`

## Requirements
- R1: Host register codes on `h_reg` are 2 = control, 3 = data, 1 = sequencer offset, and 0 = reserved (reads zero, writes ignored). The control word holds the direction in bit 31 (1 = host fills, 0 = host drains), the auto-increment enable in bit 30, and the word address in bits 7:0. Only bits 6:0 are stored, so bit 7 reads back as 0. Writing the control word reloads the word address, and the control word reads back its stored fields.
- R2: In fill direction, a host write to the data register stores the whole word at the current word address. Buffer byte 4n+k sits in bits 8k+7:8k of word n (little-endian).
- R3: A host read of the data register returns the word at the current word address on `h_rdata` in the same cycle as the access.
- R4: With auto-increment enabled, an access matching the direction (write when filling, read when draining) advances the word address by one at the clock edge that ends it. With auto-increment disabled, the address holds.
- R5: The word address wraps from 127 to 0.
- R6: A data write while draining is ignored: nothing is stored and the address does not move. A data read while filling returns the word but does not advance the address.
- R7: The sequencer offset register is 9 bits wide and reads back zero-extended. A pulse on `sq_start` loads the byte pointer from it, and takes precedence over a same-cycle byte access.
- R8: `sq_rdata` shows the byte at the pointer combinationally. Each cycle with `sq_rd` or `sq_wr` high advances the pointer by one, wrapping from 511 to 0.
- R9: `sq_wr` stores `sq_wdata` at the pointer byte.
- R10: A transfer whose length is not a multiple of four ends with one full-word access. Its low-order bytes map to the lowest buffer bytes, and on a drain the untouched upper bytes keep their previous contents.
- R11: When a host fill write and a sequencer write hit the same byte in one cycle, the host value is kept.
- R12: After reset, the direction, auto-increment, word address, offset and byte pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_en | input | 1 | Host access strobe, one access per cycle |
| h_we | input | 1 | Host write (1) or read (0) |
| h_reg | input | 2 | Host register select |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, combinational on `h_reg` |
| sq_start | input | 1 | Load the byte pointer from the offset register |
| sq_rd | input | 1 | Sequencer consumes the byte at the pointer |
| sq_wr | input | 1 | Sequencer writes `sq_wdata` at the pointer |
| sq_wdata | input | 8 | Sequencer write byte |
| sq_rdata | output | 8 | Byte at the pointer |

## Verification
The assertions assume the host makes at most one register access per cycle, so a control write never coincides with a data access, and that `h_reg` carries only the four codes above. They also assume the sequencer raises `sq_rd` and `sq_wr` only as single-cycle byte strobes, with a start pulse overriding them. The bench drives every access through one task per cycle that clears all strobes first. It never asserts both sequencer strobes together, and it only combines a host write with a sequencer write in the deliberate collision case.

// File: rtl/xbuf_pkg.sv
`timescale 1ns/1ps
package xbuf_pkg;
    localparam int HOST_DW      = 32;
    localparam int LANES        = HOST_DW / 8;
    localparam int LANE_IW      = $clog2(LANES);
    localparam int CTRL_DIR_BIT = 31;
    localparam int CTRL_INC_BIT = 30;
    localparam int CTRL_ADDR_W  = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_OFS  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_DATA = 2'd3
    } hsel_e;
endpackage

// File: rtl/xbuf_regs.sv
`timescale 1ns/1ps
module xbuf_regs #(
    parameter int WAW = 7,
    parameter int BAW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_en,
    input  logic           h_we,
    input  logic [1:0]     h_reg,
    input  logic           wr_fill,
    input  logic           wr_inc,
    input  logic [WAW-1:0] wr_addr,
    input  logic [BAW-1:0] wr_ofs,
    output logic           cfg_fill,
    output logic           cfg_inc,
    output logic [WAW-1:0] word_addr,
    output logic [BAW-1:0] seq_ofs,
    output logic           host_store
);
    import xbuf_pkg::*;

    typedef struct packed {
        logic           fill;
        logic           inc;
        logic [WAW-1:0] addr;
        logic [BAW-1:0] ofs;
    } regs_t;

    regs_t r_d, r_q;
    hsel_e sel;
    logic  data_wr, data_rd, step;

    always_comb begin
        sel        = hsel_e'(h_reg);
        r_d        = r_q;
        data_wr    = h_en && h_we && (sel == SEL_DATA);
        data_rd    = h_en && !h_we && (sel == SEL_DATA);
        host_store = data_wr && r_q.fill;
        step       = r_q.inc && ((data_wr && r_q.fill) || (data_rd && !r_q.fill));
        if (h_en && h_we && (sel == SEL_CTRL)) begin
            r_d.fill = wr_fill;
            r_d.inc  = wr_inc;
            r_d.addr = wr_addr;
        end else if (step) begin
            r_d.addr = r_q.addr + WAW'(1);
        end
        if (h_en && h_we && (sel == SEL_OFS)) begin
            r_d.ofs = wr_ofs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_fill  = r_q.fill;
    assign cfg_inc   = r_q.inc;
    assign word_addr = r_q.addr;
    assign seq_ofs   = r_q.ofs;
endmodule

// File: rtl/xbuf_seqptr.sv
`timescale 1ns/1ps
module xbuf_seqptr #(
    parameter int BAW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           adv,
    input  logic [BAW-1:0] ofs,
    output logic [BAW-1:0] ptr
);
    typedef struct packed {
        logic [BAW-1:0] ptr;
    } ptr_t;

    ptr_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (start)    p_d.ptr = ofs;
        else if (adv) p_d.ptr = p_q.ptr + BAW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ptr = p_q.ptr;
endmodule

// File: rtl/xbuf_lane.sv
`timescale 1ns/1ps
module xbuf_lane #(
    parameter int WORDS = 128,
    parameter int WAW   = $clog2(WORDS)
) (
    input  logic           clk,
    input  logic           h_we,
    input  logic [WAW-1:0] h_addr,
    input  logic [7:0]     h_byte,
    input  logic           s_we,
    input  logic [WAW-1:0] s_addr,
    input  logic [7:0]     s_byte,
    output logic [7:0]     h_q,
    output logic [7:0]     s_q
);
    logic [7:0] mem_d [WORDS];
    logic [7:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (s_we) mem_d[s_addr] = s_byte;
        if (h_we) mem_d[h_addr] = h_byte;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign h_q = mem_q[h_addr];
    assign s_q = mem_q[s_addr];
endmodule

// File: rtl/xfer_dbuf.sv
`timescale 1ns/1ps
module xfer_dbuf #(
    parameter int BUF_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h_en,
    input  logic        h_we,
    input  logic [1:0]  h_reg,
    input  logic [31:0] h_wdata,
    output logic [31:0] h_rdata,
    input  logic        sq_start,
    input  logic        sq_rd,
    input  logic        sq_wr,
    input  logic [7:0]  sq_wdata,
    output logic [7:0]  sq_rdata
);
    import xbuf_pkg::*;

    localparam int WORDS = BUF_BYTES / LANES;
    localparam int WAW   = $clog2(WORDS);
    localparam int BAW   = $clog2(BUF_BYTES);

    logic              cfg_fill, cfg_inc, host_store;
    logic [WAW-1:0]    word_addr;
    logic [BAW-1:0]    seq_ofs, seq_ptr;
    logic [HOST_DW-1:0] buf_word;
    logic [7:0]        lane_h [LANES];
    logic [7:0]        lane_s [LANES];
    logic [LANE_IW-1:0] seq_lane;
    logic [WAW-1:0]    seq_word;

    xbuf_regs #(.WAW(WAW), .BAW(BAW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_en       (h_en),
        .h_we       (h_we),
        .h_reg      (h_reg),
        .wr_fill    (h_wdata[CTRL_DIR_BIT]),
        .wr_inc     (h_wdata[CTRL_INC_BIT]),
        .wr_addr    (h_wdata[WAW-1:0]),
        .wr_ofs     (h_wdata[BAW-1:0]),
        .cfg_fill   (cfg_fill),
        .cfg_inc    (cfg_inc),
        .word_addr  (word_addr),
        .seq_ofs    (seq_ofs),
        .host_store (host_store)
    );

    xbuf_seqptr #(.BAW(BAW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sq_start),
        .adv   (sq_rd | sq_wr),
        .ofs   (seq_ofs),
        .ptr   (seq_ptr)
    );

    assign seq_lane = seq_ptr[LANE_IW-1:0];
    assign seq_word = seq_ptr[BAW-1:LANE_IW];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        xbuf_lane #(.WORDS(WORDS), .WAW(WAW)) u_lane (
            .clk    (clk),
            .h_we   (host_store),
            .h_addr (word_addr),
            .h_byte (h_wdata[8*i +: 8]),
            .s_we   (sq_wr && (seq_lane == LANE_IW'(i))),
            .s_addr (seq_word),
            .s_byte (sq_wdata),
            .h_q    (lane_h[i]),
            .s_q    (lane_s[i])
        );
        assign buf_word[8*i +: 8] = lane_h[i];
    end

    assign sq_rdata = lane_s[seq_lane];

    always_comb begin
        h_rdata = '0;
        case (hsel_e'(h_reg))
            SEL_CTRL: begin
                h_rdata[CTRL_DIR_BIT] = cfg_fill;
                h_rdata[CTRL_INC_BIT] = cfg_inc;
                h_rdata[WAW-1:0]      = word_addr;
            end
            SEL_OFS:  h_rdata[BAW-1:0] = seq_ofs;
            SEL_DATA: h_rdata = buf_word;
            default:  h_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfer_dbuf_chk.sv
`timescale 1ns/1ps
module xfer_dbuf_chk #(
    parameter int WAW = 7,
    parameter int BAW = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           h_en,
    input logic           h_we,
    input logic [1:0]     h_reg,
    input logic           in_fill,
    input logic           in_inc,
    input logic [WAW-1:0] in_addr,
    input logic           cfg_fill,
    input logic           cfg_inc,
    input logic [WAW-1:0] word_addr,
    input logic [BAW-1:0] seq_ofs,
    input logic [BAW-1:0] seq_ptr,
    input logic           sq_start,
    input logic           sq_rd,
    input logic           sq_wr
);
    logic ctrl_wr, data_acc, matched;
    assign ctrl_wr  = h_en && h_we && (h_reg == 2'd2);
    assign data_acc = h_en && (h_reg == 2'd3);
    assign matched  = data_acc && (h_we == cfg_fill);

    p_reset_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (word_addr == '0 && seq_ptr == '0 && seq_ofs == '0 && !cfg_fill && !cfg_inc));

    p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (word_addr == $past(in_addr) && cfg_fill == $past(in_fill) && cfg_inc == $past(in_inc)));

    p_autoinc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (matched && cfg_inc) |=> (word_addr == WAW'($past(word_addr) + 1'b1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !cfg_inc) |=> $stable(word_addr));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (matched && cfg_inc && (&word_addr)) |=> (word_addr == '0));

    p_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && (h_we != cfg_fill)) |=> $stable(word_addr));

    p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sq_start |=> (seq_ptr == $past(seq_ofs)));

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_start && (sq_rd || sq_wr)) |=> (seq_ptr == BAW'($past(seq_ptr) + 1'b1)));

    p_ptr_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sq_start && !sq_rd && !sq_wr) |=> $stable(seq_ptr));
endmodule

bind xfer_dbuf xfer_dbuf_chk #(.WAW(WAW), .BAW(BAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_en      (h_en),
    .h_we      (h_we),
    .h_reg     (h_reg),
    .in_fill   (h_wdata[31]),
    .in_inc    (h_wdata[30]),
    .in_addr   (h_wdata[WAW-1:0]),
    .cfg_fill  (cfg_fill),
    .cfg_inc   (cfg_inc),
    .word_addr (word_addr),
    .seq_ofs   (seq_ofs),
    .seq_ptr   (seq_ptr),
    .sq_start  (sq_start),
    .sq_rd     (sq_rd),
    .sq_wr     (sq_wr)
);

// File: tb/xfer_dbuf_test.sv
`timescale 1ns/1ps
module xfer_dbuf_test;
    localparam logic [1:0] R_NONE = 2'd0, R_OFS = 2'd1, R_CTRL = 2'd2, R_DATA = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_en = 1'b0, h_we = 1'b0;
    logic [1:0]  h_reg = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        sq_start = 1'b0, sq_rd = 1'b0, sq_wr = 1'b0;
    logic [7:0]  sq_wdata = '0;
    logic [7:0]  sq_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          q_seq [$];
    logic [31:0] q_val [$];
    string       q_tag [$];
    bit          m_seq;
    logic [31:0] m_exp, m_act;
    string       m_tag;

    always #10 clk = ~clk;

    xfer_dbuf uut (
        .clk(clk), .rst_n(rst_n), .h_en(h_en), .h_we(h_we), .h_reg(h_reg),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .sq_start(sq_start), .sq_rd(sq_rd),
        .sq_wr(sq_wr), .sq_wdata(sq_wdata), .sq_rdata(sq_rdata)
    );

    // monitor: compares one queued expectation per cycle, mid-cycle
    always @(negedge clk) begin
        if (q_val.size() > 0) begin
            m_seq = q_seq.pop_front();
            m_exp = q_val.pop_front();
            m_tag = q_tag.pop_front();
            m_act = m_seq ? {24'h0, sq_rdata} : h_rdata;
            checks++;
            if (m_act !== m_exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", m_tag, m_act, m_exp);
            end
        end
    end

    task automatic clear_in();
        h_en = 1'b0; h_we = 1'b0; h_reg = R_NONE; h_wdata = '0;
        sq_start = 1'b0; sq_rd = 1'b0; sq_wr = 1'b0; sq_wdata = '0;
    endtask

    task automatic idle();
        @(posedge clk); #1; clear_in();
    endtask

    task automatic host_wr(input logic [1:0] r, input logic [31:0] d);
        @(posedge clk); #1; clear_in();
        h_en = 1'b1; h_we = 1'b1; h_reg = r; h_wdata = d;
    endtask

    task automatic host_rd(input logic [1:0] r, input logic [31:0] e, input string tag);
        @(posedge clk); #1; clear_in();
        h_en = 1'b1; h_reg = r;
        q_seq.push_back(1'b0); q_val.push_back(e); q_tag.push_back(tag);
    endtask

    task automatic seq_go();
        @(posedge clk); #1; clear_in();
        sq_start = 1'b1;
    endtask

    task automatic seq_read(input logic [7:0] e, input string tag);
        @(posedge clk); #1; clear_in();
        sq_rd = 1'b1;
        q_seq.push_back(1'b1); q_val.push_back({24'h0, e}); q_tag.push_back(tag);
    endtask

    task automatic seq_write(input logic [7:0] b);
        @(posedge clk); #1; clear_in();
        sq_wr = 1'b1; sq_wdata = b;
    endtask

    task automatic set_offset(input logic [31:0] o);
        host_wr(R_OFS, o);
        seq_go();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        host_rd(R_CTRL, 32'h0, "R12 control after reset");
        host_rd(R_OFS,  32'h0, "R12 offset after reset");
        host_rd(R_NONE, 32'h0, "R1 reserved register reads zero");

        // R1 control fields
        host_wr(R_CTRL, 32'hC000_00FF);
        host_rd(R_CTRL, 32'hC000_007F, "R1 control readback drops bit 7");
        host_wr(R_CTRL, 32'hC000_0000);
        host_rd(R_CTRL, 32'hC000_0000, "R1 control reload address");

        // R2 fill four words, R8 sequencer drains bytes in order
        for (int n = 0; n < 4; n++)
            host_wr(R_DATA, {8'(4*n+3), 8'(4*n+2), 8'(4*n+1), 8'(4*n)});
        host_rd(R_CTRL, 32'hC000_0004, "R4 address after four fills");
        set_offset(32'h0);
        for (int i = 0; i < 16; i++)
            seq_read(8'(i), "R2 R8 little-endian byte order");

        // R10 partial final word: six bytes
        host_wr(R_CTRL, 32'hC000_0000);
        host_wr(R_DATA, 32'h4433_2211);
        host_wr(R_DATA, 32'hDEAD_6655);
        set_offset(32'h0);
        seq_read(8'h11, "R10 partial byte 0");
        seq_read(8'h22, "R10 partial byte 1");
        seq_read(8'h33, "R10 partial byte 2");
        seq_read(8'h44, "R10 partial byte 3");
        seq_read(8'h55, "R10 partial byte 4");
        seq_read(8'h66, "R10 partial byte 5");

        // R9 sequencer writes, R3 R4 host drain
        set_offset(32'd8);
        for (int i = 0; i < 6; i++) seq_write(8'hA0 + 8'(i));
        host_wr(R_CTRL, 32'h4000_0002);
        host_rd(R_DATA, 32'hA3A2_A1A0, "R3 R9 drain word 2");
        host_rd(R_DATA, 32'h0F0E_A5A4, "R4 R10 drain partial word 3");
        host_rd(R_CTRL, 32'h4000_0004, "R4 address after two drains");

        // R4 no auto-increment holds the address
        host_wr(R_CTRL, 32'h0000_0002);
        host_rd(R_DATA, 32'hA3A2_A1A0, "R4 hold first read");
        host_rd(R_DATA, 32'hA3A2_A1A0, "R4 hold second read");

        // R6 direction mismatch
        host_wr(R_CTRL, 32'h4000_0002);
        host_wr(R_DATA, 32'h1234_5678);
        host_rd(R_DATA, 32'hA3A2_A1A0, "R6 drain-mode write ignored");
        host_wr(R_CTRL, 32'hC000_0002);
        host_rd(R_DATA, 32'hA3A2_A1A0, "R6 fill-mode read returns word");
        host_rd(R_CTRL, 32'hC000_0002, "R6 fill-mode read no advance");
        host_wr(R_DATA, 32'h55AA_55AA);
        host_wr(R_CTRL, 32'h0000_0002);
        host_rd(R_DATA, 32'h55AA_55AA, "R2 fill store after mismatch");

        // R5 word address wrap
        host_wr(R_CTRL, 32'hC000_007F);
        host_wr(R_DATA, 32'h7F7F_7F7F);
        host_wr(R_DATA, 32'h0000_AAAA);
        host_rd(R_CTRL, 32'hC000_0001, "R5 address wrapped to 1");
        host_wr(R_CTRL, 32'h0000_0000);
        host_rd(R_DATA, 32'h0000_AAAA, "R5 wrapped write landed in word 0");
        host_wr(R_CTRL, 32'h0000_007F);
        host_rd(R_DATA, 32'h7F7F_7F7F, "R5 word 127 contents");

        // R8 pointer wrap 511 -> 0
        set_offset(32'd511);
        seq_read(8'h7F, "R8 byte 511");
        seq_read(8'hAA, "R8 pointer wrapped to byte 0");

        // R7 offset register width and start precedence
        host_wr(R_OFS, 32'hFFFF_FFFF);
        host_rd(R_OFS, 32'h0000_01FF, "R7 offset is 9 bits");
        host_wr(R_OFS, 32'd4);
        @(posedge clk); #1; clear_in(); sq_start = 1'b1; sq_rd = 1'b1;
        seq_read(8'h55, "R7 start wins over same-cycle read");

        // R11 collision on byte 64 (word 16 lane 0)
        host_wr(R_CTRL, 32'hC000_0010);
        set_offset(32'd64);
        @(posedge clk); #1; clear_in();
        h_en = 1'b1; h_we = 1'b1; h_reg = R_DATA; h_wdata = 32'h1111_1111;
        sq_wr = 1'b1; sq_wdata = 8'h99;
        seq_read(8'h11, "R11 R8 next byte after collision");
        host_wr(R_CTRL, 32'h0000_0010);
        host_rd(R_DATA, 32'h1111_1111, "R11 host value kept on collision");

        idle();
        idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule